// File: doc/BRIEF.md
# Transmit Standby and Fast Exit Controller

This block manages the low-power standby of a single transmit direction of a serial link. While the link is operational, a standby request makes the controller emit one electrical idle ordered set and then stop driving the lane. The transmitter stays quiet for as long as nothing is waiting to be sent. When traffic becomes pending, the controller sends a burst of fast training sequences so that the far-end receiver can re-acquire bit and symbol lock, and then it hands the lane back to normal traffic. The receive direction is not involved and may stay fully operational during the whole episode.

The number of fast training sequences is the count that the link partner asked for during configuration. The controller captures it, together with an extended-synch override, in the cycle the standby request is accepted. The override replaces that count with a fixed long burst of 4096 sequences. A count of zero is treated as one sequence. Every ordered set occupies `SET_CYCLES` output cycles, and the sequence counter steps down once per completed set. If the partner reports a lock failure at the end of the burst, the controller raises a one-cycle recovery request instead of returning directly to the operational state.

States and transitions, by state code: ACTIVE (0) goes to SEND_EIOS (1) on an entry request. SEND_EIOS goes to QUIET (2) when its ordered set completes. QUIET goes to SEND_FTS (3) when traffic is pending. SEND_FTS goes to ACTIVE after its last set, or to RECOVER (4) if lock failure is flagged in that final cycle. RECOVER always goes back to ACTIVE after one cycle.

Top module: `txs_ctrl`

## Requirements
- R1: After reset, the state code is 0 (ACTIVE), the ordered-set select is 0 (none), the transmit-idle flag is 0 and the recovery request is 0.
- R2: An entry request seen in ACTIVE moves the controller to state code 1 on the next cycle, where the select is 1 (EIOS) and the idle flag is 0 for exactly SET_CYCLES cycles.
- R3: After the EIOS the state code is 2 with the idle flag at 1 and the select at 0. The state persists while traffic-pending is low, and traffic-pending during the EIOS does not shorten the EIOS.
- R4: Traffic-pending high in state 2 moves to state code 3, where the select is 2 (FTS) and the idle flag is 0, for N×SET_CYCLES cycles. N is the fast-training count sampled in the entry cycle; later changes of that input have no effect.
- R5: A sampled count of zero gives N = 1.
- R6: The extended-synch bit sampled in the entry cycle forces N = 4096; later changes of that bit have no effect.
- R7: If lock-failure is low in the final FTS cycle, the next state code is 0.
- R8: If lock-failure is high in the final FTS cycle, the next state code is 4 with the recovery request at 1 for one cycle, followed by state code 0.
- R9: An entry request in any state other than ACTIVE, including the final FTS cycle and RECOVER, is ignored; the controller is in ACTIVE afterwards and stays there while the request is low.
- R10: In ACTIVE, traffic-pending and lock-failure have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Request to enter transmit standby |
| traffic_pend | input | 1 | Packets are waiting to be sent |
| nfts_val | input | NFTS_W | Negotiated fast training sequence count |
| ext_sync | input | 1 | Force the long fixed exit burst |
| lock_fail | input | 1 | Partner failed to regain lock |
| os_sel | output | 2 | Ordered set this cycle: 0 none, 1 EIOS, 2 FTS |
| tx_eidle | output | 1 | Transmitter held in electrical idle |
| state_code | output | 3 | Current state code (0 to 4) |
| recov_req | output | 1 | One-cycle request to enter recovery |

## Verification
Two events can land in the same cycle: the end of the exit burst and a fresh standby request, or the end of the burst and a lock-failure report. The bench holds the entry request high through the whole exit, including the final FTS cycle and the recovery cycle. It then checks that the state lands in ACTIVE, or in RECOVER for one cycle, and not back in SEND_EIOS. The lock-failure input is held high across an entire burst, so its effect in the final cycle is judged by the single recovery pulse and the return to ACTIVE that follows.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_EIOS   = 3'd1,
        ST_QUIET  = 3'd2,
        ST_FTS    = 3'd3,
        ST_RECOV  = 3'd4
    } txs_state_e;

    typedef enum logic [1:0] {
        OS_NONE = 2'd0,
        OS_EIOS = 2'd1,
        OS_FTS  = 2'd2
    } txs_os_e;
endpackage

// File: rtl/txs_beat_timer.sv
module txs_beat_timer #(
    parameter int SET_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic set_done
);
    localparam int BEAT_W = (SET_CYCLES > 1) ? $clog2(SET_CYCLES) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(SET_CYCLES - 1);

    logic [BEAT_W-1:0] beat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (!run || beat == LAST_BEAT) begin
            beat <= '0;
        end else begin
            beat <= beat + 1'b1;
        end
    end

    assign set_done = run && (beat == LAST_BEAT);

    // R2
    beat_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> beat == '0);
endmodule

// File: rtl/txs_seq_count.sv
module txs_seq_count #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt != '0);
endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl #(
    parameter int SET_CYCLES = 4,
    parameter int NFTS_W     = 8,
    parameter int EXT_FTS    = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_req,
    input  logic              traffic_pend,
    input  logic [NFTS_W-1:0] nfts_val,
    input  logic              ext_sync,
    input  logic              lock_fail,
    output logic [1:0]        os_sel,
    output logic              tx_eidle,
    output logic [2:0]        state_code,
    output logic              recov_req
);
    import txs_pkg::*;

    localparam int EXT_W = $clog2(EXT_FTS + 1);
    localparam int CNT_W = (EXT_W > NFTS_W) ? EXT_W : NFTS_W;

    txs_state_e       state, state_nx;
    txs_os_e          os_cur;
    logic             run, set_done, seq_last, seq_load, seq_dec;
    logic [CNT_W-1:0] load_val;

    assign run      = (state == ST_EIOS) || (state == ST_FTS);
    assign seq_load = (state == ST_ACTIVE) && enter_req;
    assign seq_dec  = (state == ST_FTS) && set_done;

    always_comb begin
        if (ext_sync) begin
            load_val = CNT_W'(EXT_FTS);
        end else if (nfts_val == '0) begin
            load_val = CNT_W'(1);
        end else begin
            load_val = CNT_W'(nfts_val);
        end
    end

    txs_beat_timer #(.SET_CYCLES(SET_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .set_done (set_done)
    );

    txs_seq_count #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .load_val (load_val),
        .dec      (seq_dec),
        .last     (seq_last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACTIVE: if (enter_req) state_nx = ST_EIOS;
            ST_EIOS:   if (set_done) state_nx = ST_QUIET;
            ST_QUIET:  if (traffic_pend) state_nx = ST_FTS;
            ST_FTS: begin
                if (set_done && seq_last) begin
                    state_nx = lock_fail ? ST_RECOV : ST_ACTIVE;
                end
            end
            ST_RECOV:  state_nx = ST_ACTIVE;
            default:   state_nx = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ACTIVE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        os_cur    = OS_NONE;
        tx_eidle  = 1'b0;
        recov_req = 1'b0;
        unique case (state)
            ST_ACTIVE: ;
            ST_EIOS:   os_cur = OS_EIOS;
            ST_QUIET:  tx_eidle = 1'b1;
            ST_FTS:    os_cur = OS_FTS;
            ST_RECOV:  recov_req = 1'b1;
            default:   ;
        endcase
    end

    assign os_sel     = os_cur;
    assign state_code = state;

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUIET && !traffic_pend) |=> state == ST_QUIET);

    // R2
    eidle_after_eios_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_eidle) |-> $past(os_sel) == 2'd1);

    // R8
    recov_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recov_req |=> (state == ST_ACTIVE && !recov_req));

    // R9
    no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FTS || state == ST_RECOV) |=> state != ST_EIOS);
endmodule

// File: tb/txs_ctrl_test.sv
`timescale 1ns/1ps
module txs_ctrl_test;
    localparam int SETC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enter_req = 1'b0;
    logic       traffic_pend = 1'b0;
    logic [7:0] nfts_val = 8'd0;
    logic       ext_sync = 1'b0;
    logic       lock_fail = 1'b0;
    logic [1:0] os_sel;
    logic       tx_eidle;
    logic [2:0] state_code;
    logic       recov_req;

    typedef struct {
        int st;
        int req;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;
    int   cycles = 0;

    always #10 clk = ~clk;

    txs_ctrl #(.SET_CYCLES(SETC), .NFTS_W(8), .EXT_FTS(4096)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_req    (enter_req),
        .traffic_pend (traffic_pend),
        .nfts_val     (nfts_val),
        .ext_sync     (ext_sync),
        .lock_fail    (lock_fail),
        .os_sel       (os_sel),
        .tx_eidle     (tx_eidle),
        .state_code   (state_code),
        .recov_req    (recov_req)
    );

    task automatic compare(input int st, input int req);
        int eos;
        bit eid, erq;
        eos = (st == 1) ? 1 : ((st == 3) ? 2 : 0);
        eid = (st == 2);
        erq = (st == 4);
        vectors++;
        if (int'(state_code) != st || int'(os_sel) != eos ||
            tx_eidle != eid || recov_req != erq) begin
            miscompares++;
            $display("FAIL R%0d: state=%0d os=%0d eidle=%0b rq=%0b expected state=%0d os=%0d eidle=%0b rq=%0b",
                     req, state_code, os_sel, tx_eidle, recov_req, st, eos, eid, erq);
        end
    endtask

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            compare(e.st, e.req);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // driver: set inputs for one cycle and queue the state expected after the edge
    task automatic step(input bit en, input bit pend, input logic [7:0] n,
                        input bit ex, input bit lf, input int st, input int req);
        @(negedge clk);
        #1;
        enter_req    = en;
        traffic_pend = pend;
        nfts_val     = n;
        ext_sync     = ex;
        lock_fail    = lf;
        q.push_back('{st, req});
    endtask

    // one full standby episode
    task automatic standby(input logic [7:0] n, input bit ex, input int idle,
                           input bit lockf, input bit pend_early, input bit noisy);
        int nseq;
        logic [7:0] nn;
        bit xx;
        nseq = ex ? 4096 : ((n == 0) ? 1 : int'(n));
        nn = noisy ? ~n : n;
        xx = noisy ? ~ex : ex;
        // R2: entry and EIOS length
        step(1'b1, pend_early, n, ex, 1'b0, 1, 2);
        for (int i = 1; i < SETC; i++) step(noisy, pend_early, nn, xx, 1'b0, 1, 2);
        // R3: quiet persists, early traffic ignored
        for (int i = 0; i < idle; i++)
            step(noisy, (i == 0) ? pend_early : 1'b0, nn, xx, 1'b0, 2, 3);
        // R4 / R5 / R6: burst length from the sampled count
        for (int i = 0; i < nseq * SETC; i++) step(noisy, 1'b1, nn, xx, lockf, 3, 4);
        // R7 / R8: outcome of the final cycle
        step(noisy, 1'b0, nn, xx, lockf, lockf ? 4 : 0, lockf ? 8 : 7);
        if (lockf) step(noisy, 1'b0, nn, xx, 1'b0, 0, 8);
        // R9: entry requests during the exit left no trace
        step(1'b0, 1'b0, nn, xx, 1'b0, 0, 9);
        step(1'b0, 1'b0, nn, xx, 1'b0, 0, 9);
    endtask

    initial begin
        #45;
        // R1: reset state
        compare(0, 1);
        rst_n = 1'b1;
        // R1 after release
        step(1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 0, 1);
        // R10: traffic and lock failure in ACTIVE have no effect
        step(1'b0, 1'b1, 8'd7, 1'b0, 1'b1, 0, 10);
        step(1'b0, 1'b1, 8'd7, 1'b1, 1'b1, 0, 10);
        step(1'b0, 1'b0, 8'd7, 1'b0, 1'b0, 0, 10);
        // R4, R7: plain episode
        standby(8'd3, 1'b0, 3, 1'b0, 1'b0, 1'b0);
        // R5, R3: zero count, traffic already pending during EIOS
        standby(8'd0, 1'b0, 1, 1'b0, 1'b1, 1'b0);
        // R8: lock failure at the end of the burst
        standby(8'd5, 1'b0, 2, 1'b1, 1'b0, 1'b0);
        // R9, R4, R6: requests and input changes during the episode are ignored
        standby(8'd2, 1'b0, 4, 1'b0, 1'b0, 1'b1);
        // R9, R8: entry held through the recovery pulse
        standby(8'd1, 1'b0, 1, 1'b1, 1'b0, 1'b1);
        // R6: extended synch burst
        standby(8'd2, 1'b1, 2, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule